// File: doc/BRIEF.md
# Thread Block Register Admission Unit

This unit sits in front of one multiprocessor and decides, one request at a time, whether a new thread block can be made resident. A request gives the number of threads in the block and the number of 32-bit registers each thread needs. The unit rounds the thread count up to whole 32-thread warps and charges the block for the registers of every thread in those warps. It checks that charge against the registers still free out of the 8192-register file, and the block's warps against the warp slots still free.

An accepted block gets a contiguous register range taken from a bump pointer. The unit reports the first register of that range and the number of warps it created. Registers and warp slots come back through a release strobe. A release always retires the most recently admitted block that is still resident. Register storage, instruction issue and barrier handling are outside this unit.

Top module: `adm_unit`

## Requirements
- R1: After reset no block is resident and `resp_valid` is low; the first accepted block receives base 0.
- R2: A request with zero threads or zero registers per thread is rejected.
- R3: A request with more than 512 threads is rejected.
- R4: The warp count is ceil(threads/32), and the register demand is warps*32*registers-per-thread. A request whose demand exceeds 8192 minus the registers in use is rejected.
- R5: A request that would raise the total resident warps above 24 is rejected.
- R6: An accepted block's base equals the bump pointer, which is the sum of the demands of all resident blocks. Acceptance advances the pointer by the demand.
- R7: A release retires the newest resident block and returns its registers and warps. A release with no resident block has no effect.
- R8: A request that arrives in the same cycle as a release is rejected, and the release is still carried out.
- R9: `resp_valid` is high exactly in the cycle after each request. A rejection reports base 0 and warps 0, and an acceptance reports the warp count from R4.
- R10: A rejected request leaves the pointer and the warp count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Admission request strobe |
| req_threads | input | 10 | Threads in the requested block |
| req_regs | input | 8 | Registers needed per thread |
| rel_valid | input | 1 | Retire the newest resident block |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_accept | output | 1 | 1 = admitted, 0 = rejected |
| resp_base | output | 14 | First register of the granted range |
| resp_warps | output | 5 | Warps created for the block |

## Verification
The bench goes after several edges.

- **Exact fill.** It requests a full file of 8192 registers from an empty state, then one more register. A comparison written as strictly-less would reject the full file; a missing check would accept the extra register.
- **Warp rounding.** It uses thread counts just past a multiple of 32. A block charged on its raw thread count would get too small a demand and the wrong base for the next block.
- **Thread limit.** It asks for 512 threads and then 513, which exposes an off-by-one in the limit.
- **Warp cap.** It fills exactly 24 single-warp blocks and then adds one more. A broken cap would accept the 25th.
- **Release order.** Releases against an empty stack would corrupt the pointer if they were not ignored. Releases in newest-first order show up as wrong bases on later grants if the stack pops the wrong entry.
- **Collision.** A release in the same cycle as a request must reject the request and still free the space.

// File: rtl/adm_pkg.sv
// Shared sizing constants for the block admission unit.
package adm_pkg;
    localparam int LANES             = 8;
    localparam int LANE_REGS         = 1024;
    localparam int WARP_SIZE         = 32;
    localparam int MAX_BLOCK_THREADS = 512;
    localparam int MAX_WARPS         = 24;
    localparam int THR_W             = 10;
    localparam int REG_W             = 8;
endpackage

// File: rtl/adm_sizer.sv
// adm_sizer: turns a thread count and per-thread register need into a warp
// count and a register demand. Purely combinational.
// Assumes WARP_SIZE is a power of two and THR_W > log2(WARP_SIZE).
module adm_sizer #(
    parameter int THR_W     = 10,
    parameter int REG_W     = 8,
    parameter int WARP_SIZE = 32,
    localparam int WARP_LOG = $clog2(WARP_SIZE),
    localparam int WC_W     = THR_W - WARP_LOG + 1,
    localparam int DEM_W    = WC_W + WARP_LOG + REG_W
) (
    input  logic [THR_W-1:0] threads,
    input  logic [REG_W-1:0] regs,
    output logic [WC_W-1:0]  warps,
    output logic [DEM_W-1:0] demand
);
    logic [THR_W:0] rounded;

    // Round threads up to whole warps, then charge every slot of those warps.
    always_comb begin
        rounded = {1'b0, threads} + (THR_W+1)'(WARP_SIZE - 1);
        warps   = rounded[THR_W:WARP_LOG];
        demand  = DEM_W'({warps, {WARP_LOG{1'b0}}}) * DEM_W'(regs);
    end
endmodule

// File: rtl/adm_stack.sv
// adm_stack: last-in-first-out record of resident blocks (base, warps).
// Assumes the caller never pushes beyond DEPTH and never pushes and pops
// in the same cycle; a pop on an empty stack is dropped here.
module adm_stack #(
    parameter int DEPTH = 24,
    parameter int BW    = 14,
    parameter int WW    = 5,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [BW-1:0] push_base,
    input  logic [WW-1:0] push_warps,
    input  logic          pop,
    output logic          empty,
    output logic [BW-1:0] top_base,
    output logic [WW-1:0] top_warps
);
    logic [BW-1:0] ent_base  [DEPTH];
    logic [WW-1:0] ent_warps [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] top_idx;
    logic          pop_en;

    assign empty   = (cnt == '0);
    assign pop_en  = pop && !empty;
    assign top_idx = cnt - 1'b1;

    // Present the newest record; meaningful only when not empty.
    always_comb begin
        top_base  = '0;
        top_warps = '0;
        if (!empty) begin
            top_base  = ent_base[top_idx[AW-1:0]];
            top_warps = ent_warps[top_idx[AW-1:0]];
        end
    end

    // Track the number of resident records.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (push)   cnt <= cnt + 1'b1;
        else if (pop_en) cnt <= cnt - 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            // Each slot captures a record when it is the next free slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_base[g]  <= '0;
                    ent_warps[g] <= '0;
                end else if (push && cnt == CW'(g)) begin
                    ent_base[g]  <= push_base;
                    ent_warps[g] <= push_warps;
                end
            end
        end
    endgenerate

    a_r8_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (cnt == '0));
    a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/adm_unit.sv
// adm_unit: admits thread blocks onto one multiprocessor against a register
// budget and a warp-slot budget, granting contiguous register ranges from a
// bump pointer and returning them newest-first on release.
// Assumes one request per cycle at most; a request colliding with a release
// is rejected.
module adm_unit #(
    parameter int LANES             = adm_pkg::LANES,
    parameter int LANE_REGS         = adm_pkg::LANE_REGS,
    parameter int WARP_SIZE         = adm_pkg::WARP_SIZE,
    parameter int MAX_BLOCK_THREADS = adm_pkg::MAX_BLOCK_THREADS,
    parameter int MAX_WARPS         = adm_pkg::MAX_WARPS,
    parameter int THR_W             = adm_pkg::THR_W,
    parameter int REG_W             = adm_pkg::REG_W,
    localparam int REG_TOTAL        = LANES * LANE_REGS,
    localparam int PW               = $clog2(REG_TOTAL + 1),
    localparam int WW               = $clog2(MAX_WARPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [THR_W-1:0] req_threads,
    input  logic [REG_W-1:0] req_regs,
    input  logic             rel_valid,
    output logic             resp_valid,
    output logic             resp_accept,
    output logic [PW-1:0]    resp_base,
    output logic [WW-1:0]    resp_warps
);
    localparam int WARP_LOG = $clog2(WARP_SIZE);
    localparam int WC_W     = THR_W - WARP_LOG + 1;
    localparam int DEM_W    = WC_W + WARP_LOG + REG_W;

    logic [WC_W-1:0]  blk_warps;
    logic [DEM_W-1:0] blk_demand;
    logic [PW-1:0]    ptr;
    logic [WW-1:0]    used;
    logic             stk_empty;
    logic [PW-1:0]    top_base;
    logic [WW-1:0]    top_warps;
    logic             admit;
    logic             retire;

    adm_sizer #(.THR_W(THR_W), .REG_W(REG_W), .WARP_SIZE(WARP_SIZE)) u_sizer (
        .threads (req_threads),
        .regs    (req_regs),
        .warps   (blk_warps),
        .demand  (blk_demand)
    );

    adm_stack #(.DEPTH(MAX_WARPS), .BW(PW), .WW(WW)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (admit),
        .push_base  (ptr),
        .push_warps (blk_warps[WW-1:0]),
        .pop        (rel_valid),
        .empty      (stk_empty),
        .top_base   (top_base),
        .top_warps  (top_warps)
    );

    // Admission decision against all limits.
    always_comb begin
        admit = req_valid && !rel_valid
             && (req_threads != '0) && (req_regs != '0)
             && (32'(req_threads) <= MAX_BLOCK_THREADS)
             && (32'(blk_demand) <= REG_TOTAL - 32'(ptr))
             && (32'(blk_warps) <= MAX_WARPS - 32'(used));
        retire = rel_valid && !stk_empty;
    end

    // Bump pointer and warp occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            used <= '0;
        end else if (retire) begin
            ptr  <= top_base;
            used <= used - top_warps;
        end else if (admit) begin
            ptr  <= ptr + PW'(blk_demand);
            used <= used + WW'(blk_warps);
        end
    end

    // Registered response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
            resp_base   <= '0;
            resp_warps  <= '0;
        end else begin
            resp_valid  <= req_valid;
            resp_accept <= admit;
            resp_base   <= admit ? ptr : '0;
            resp_warps  <= admit ? WW'(blk_warps) : '0;
        end
    end

    a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    a_r9_reject_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_accept) |-> (resp_base == '0 && resp_warps == '0));
    a_r2_zero_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_threads == '0 || req_regs == '0)) |=> !resp_accept);
    a_r3_oversize_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_threads) > MAX_BLOCK_THREADS) |=> !resp_accept);
    a_r8_collide_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rel_valid) |=> !resp_accept);
    a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) <= REG_TOTAL);
    a_r5_warp_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(used) <= MAX_WARPS);
    a_r10_reject_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rel_valid && !admit) |=> $stable(ptr));
endmodule

// File: tb/sim_adm_unit.sv
`timescale 1ns/1ps
module sim_adm_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_threads = '0;
    logic [7:0] req_regs = '0;
    logic       rel_valid = 1'b0;
    logic       resp_valid;
    logic       resp_accept;
    logic [13:0] resp_base;
    logic [4:0]  resp_warps;

    int errors = 0;
    int checks = 0;
    int m_ptr = 0;
    int m_used = 0;
    int m_sp = 0;
    int m_base [0:31];
    int m_warp [0:31];
    bit done = 0;

    always #2.5 clk = ~clk;

    adm_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
        .req_regs(req_regs), .rel_valid(rel_valid), .resp_valid(resp_valid),
        .resp_accept(resp_accept), .resp_base(resp_base), .resp_warps(resp_warps)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int warps_of(int t);
        return (t + 31) / 32;
    endfunction

    // One request/release cycle; checks the response against the model.
    task automatic step(bit rq, int thr, int rg, bit rl, string tag);
        int w, d, ok;
        req_valid = rq; req_threads = 10'(thr); req_regs = 8'(rg); rel_valid = rl;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; rel_valid = 0;
        w = warps_of(thr);
        d = w * 32 * rg;
        ok = rq && !rl && thr != 0 && rg != 0 && thr <= 512
             && d <= 8192 - m_ptr && w <= 24 - m_used;
        check({tag, " R9 valid"}, resp_valid, rq);
        if (rq) begin
            check({tag, " R4 accept"}, resp_accept, ok);
            check({tag, " R6 base"}, resp_base, ok ? m_ptr : 0);
            check({tag, " R9 warps"}, resp_warps, ok ? w : 0);
        end
        if (rl && m_sp > 0) begin
            m_sp--;
            m_ptr = m_base[m_sp];
            m_used -= m_warp[m_sp];
        end else if (ok) begin
            m_base[m_sp] = m_ptr;
            m_warp[m_sp] = w;
            m_sp++;
            m_ptr += d;
            m_used += w;
        end
    endtask

    task automatic drain();
        while (m_sp > 0) step(0, 0, 0, 1, "drain R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset resp_valid", resp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle resp_valid", resp_valid, 0);

        step(1, 256, 32, 0, "R1 first full");      // base 0, 8 warps, 8192 regs
        step(1, 32, 1, 0, "R4 over budget");
        step(0, 0, 0, 1, "R7 release");
        step(1, 1, 16, 0, "R4 round up");          // 1 warp, 512 regs
        step(1, 33, 2, 0, "R6 after rounded");     // base 512, 2 warps
        step(0, 0, 0, 1, "R7 pop newest");
        step(1, 40, 1, 0, "R6 reuse");              // base 512 again
        drain();
        step(0, 0, 0, 1, "R7 empty release");
        step(1, 0, 8, 0, "R2 zero threads");
        step(1, 64, 0, 0, "R2 zero regs");
        step(1, 513, 1, 0, "R3 over limit");
        step(1, 512, 16, 0, "R3 at limit");
        step(1, 1, 1, 0, "R4 exact full");
        drain();
        for (int i = 0; i < 25; i++) step(1, 32, 1, 0, "R5 warp cap");
        step(1, 1, 1, 1, "R8 collide");
        step(1, 32, 1, 0, "R5 after collide");
        drain();
        step(1, 64, 8, 0, "R10 setup");
        step(1, 600, 8, 0, "R10 reject");
        step(1, 32, 4, 0, "R10 next base");
        drain();

        for (int i = 0; i < 4000; i++) begin
            int r, t, g;
            bit rq, rl;
            r = $urandom % 100;
            rq = (r >= 20); rl = (r < 25);
            r = $urandom % 100;
            if (r < 5) t = 0;
            else if (r < 10) t = 513 + $urandom % 500;
            else t = 1 + $urandom % 512;
            g = ($urandom % 100 < 3) ? 0 : 1 + $urandom % 64;
            if ($urandom % 2 == 1) g = 1 + $urandom % 8;
            step(rq, t, g, rl, "rand");
        end
        drain();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule